// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits in front of one streaming multiprocessor and decides whether a launched thread block may become resident there. A request carries a block identifier and a thread count. The block is admitted only as a whole: it needs a free residency slot and enough thread capacity left for all of its threads. Otherwise the launch port applies backpressure until a resident block finishes. Requests whose thread count is zero or above the per-block maximum are taken off the port and answered with a rejection.

An admitted block is given the lowest-numbered free slot. Every slot owns a fixed range of warp identifiers, and the grant reports how many 32-thread warps the block occupies, where its range starts and which lanes of its last warp hold threads. Warps hold consecutive, increasing thread ids, so warp 0 starts at thread 0. A completion pulse naming a slot returns that slot and its threads to the free pools at the next clock edge. Blocks may finish in any order.

Top module: `block_admit_ctrl`

## Requirements
- R1: No more than MAX_BLOCKS (8) blocks are resident at once. While every slot is taken, `launch_ready` is low for any legal request.
- R2: The sum of thread counts of resident blocks never exceeds MAX_THREADS (1536). A legal request whose count would push the sum above that limit sees `launch_ready` low, even when a slot is free.
- R3: A request with thread count 0 or greater than MAX_BLOCK_THREADS (1024) sees `launch_ready` high. When it is taken, `reject_valid` pulses in the following cycle with `reject_block_id` equal to the request's id. No slot or thread capacity changes, and no grant is issued.
- R4: One cycle after a legal request is taken, `grant_valid` pulses for one cycle. `grant_block_id` equals the request id, and `grant_warps` equals the thread count divided by 32, rounded up (for example, 256 threads give 8 warps).
- R5: The grant names the lowest-numbered slot that was free at the handshake edge in `grant_slot`. `grant_base_warp` equals slot × 32, so each slot owns warp ids base to base+31.
- R6: In `grant_tail_mask`, bit i is set when lane i of the block's last warp holds a thread. This is the low (count mod 32) bits, or all 32 bits when the count is a multiple of 32.
- R7: A `done_valid` pulse naming an occupied slot frees that slot and its threads at that clock edge, so `launch_ready` reflects the freed capacity in the next cycle. A pulse naming a free slot has no effect.
- R8: A launch handshake and a completion in the same cycle both take effect. Completions may come in any order relative to launches.
- R9: After reset no slot is occupied, `grant_valid` and `reject_valid` are low, and a 1024-thread request sees `launch_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_valid | input | 1 | Launch request present |
| launch_ready | output | 1 | Request can be taken this cycle |
| launch_block_id | input | ID_W | Identifier of the requested block |
| launch_threads | input | REQ_W | Thread count of the requested block |
| done_valid | input | 1 | Completion pulse |
| done_slot | input | SLOT_W | Slot of the completed block |
| grant_valid | output | 1 | Admission result pulse |
| grant_block_id | output | ID_W | Identifier of the admitted block |
| grant_slot | output | SLOT_W | Slot assigned to the block |
| grant_warps | output | WCNT_W | Number of warps in the block |
| grant_base_warp | output | WID_W | First warp id of the slot's range |
| grant_tail_mask | output | WARP_LANES | Active lanes of the last warp |
| reject_valid | output | 1 | Rejection pulse for an illegal count |
| reject_block_id | output | ID_W | Identifier of the rejected block |

## Verification
A wrong occupancy bit or thread ledger entry does not show at the ports right away. It shows as `launch_ready` disagreeing with the expected value, or as a grant naming an unexpected slot. This happens the first time the pools come near a limit or a lowest-free-slot decision depends on the corrupted entry. The bench keeps its own model of the slots and the thread sum and compares ready before every edge and each response one cycle later. Directed sequences fill both limits exactly, free slots out of order and overlap completions with launches, so a stale or leaked entry is exposed within a few cycles.

// File: rtl/block_admit_ctrl.sv
module block_admit_ctrl #(
  parameter int MAX_BLOCKS        = 8,
  parameter int MAX_THREADS       = 1536,
  parameter int MAX_BLOCK_THREADS = 1024,
  parameter int WARP_LANES        = 32,
  parameter int ID_W              = 16,
  parameter int REQ_W             = 16,
  localparam int SLOT_W   = $clog2(MAX_BLOCKS),
  localparam int WPS      = (MAX_BLOCK_THREADS + WARP_LANES - 1) / WARP_LANES,
  localparam int WCNT_W   = $clog2(WPS + 1),
  localparam int WID_W    = $clog2(MAX_BLOCKS * WPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  launch_valid,
  output logic                  launch_ready,
  input  logic [ID_W-1:0]       launch_block_id,
  input  logic [REQ_W-1:0]      launch_threads,
  input  logic                  done_valid,
  input  logic [SLOT_W-1:0]     done_slot,
  output logic                  grant_valid,
  output logic [ID_W-1:0]       grant_block_id,
  output logic [SLOT_W-1:0]     grant_slot,
  output logic [WCNT_W-1:0]     grant_warps,
  output logic [WID_W-1:0]      grant_base_warp,
  output logic [WARP_LANES-1:0] grant_tail_mask,
  output logic                  reject_valid,
  output logic [ID_W-1:0]       reject_block_id
);
  localparam int LANE_W = $clog2(WARP_LANES);
  localparam int TCNT_W = $clog2(MAX_BLOCK_THREADS + 1);
  localparam int TOT_W  = $clog2(MAX_THREADS + 1);
  localparam int SUM_W  = $clog2(MAX_THREADS + MAX_BLOCK_THREADS + 1);

  logic [MAX_BLOCKS-1:0] occ_q;
  logic [TCNT_W-1:0]     held_q [MAX_BLOCKS];
  logic [TOT_W-1:0]      total_q;

  logic              legal, any_free, fits, take, drop, release_c;
  logic [SLOT_W-1:0] free_idx;
  logic [TCNT_W-1:0] req_t;
  logic [TCNT_W:0]   wsum;
  logic [LANE_W-1:0] rem;
  logic [SUM_W-1:0]  sum_c;

  assign legal = (launch_threads != '0) && (launch_threads <= REQ_W'(MAX_BLOCK_THREADS));
  assign req_t = TCNT_W'(launch_threads);

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int s = MAX_BLOCKS - 1; s >= 0; s--) begin
      if (!occ_q[s]) begin
        any_free = 1'b1;
        free_idx = SLOT_W'(s);
      end
    end
  end

  assign sum_c        = SUM_W'(total_q) + SUM_W'(req_t);
  assign fits         = any_free && (sum_c <= SUM_W'(MAX_THREADS));
  assign launch_ready = !legal || fits;
  assign take         = launch_valid && launch_ready && legal;
  assign drop         = launch_valid && launch_ready && !legal;
  assign release_c    = done_valid && occ_q[done_slot];

  assign wsum = {1'b0, req_t} + (TCNT_W+1)'(WARP_LANES - 1);
  assign rem  = req_t[LANE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q   <= '0;
      total_q <= '0;
      for (int s = 0; s < MAX_BLOCKS; s++) held_q[s] <= '0;
    end else begin
      total_q <= total_q + (take ? TOT_W'(req_t) : '0)
                         - (release_c ? TOT_W'(held_q[done_slot]) : '0);
      if (release_c) occ_q[done_slot] <= 1'b0;
      if (take) begin
        occ_q[free_idx]  <= 1'b1;
        held_q[free_idx] <= req_t;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid     <= 1'b0;
      grant_block_id  <= '0;
      grant_slot      <= '0;
      grant_warps     <= '0;
      grant_base_warp <= '0;
      grant_tail_mask <= '0;
      reject_valid    <= 1'b0;
      reject_block_id <= '0;
    end else begin
      grant_valid  <= take;
      reject_valid <= drop;
      if (take) begin
        grant_block_id  <= launch_block_id;
        grant_slot      <= free_idx;
        grant_warps     <= WCNT_W'(wsum >> LANE_W);
        grant_base_warp <= WID_W'(int'(free_idx) * WPS);
        grant_tail_mask <= (rem == '0) ? {WARP_LANES{1'b1}}
                                       : ~({WARP_LANES{1'b1}} << rem);
      end
      if (drop) reject_block_id <= launch_block_id;
    end
  end

  AST_THREAD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    total_q <= TOT_W'(MAX_THREADS)); // R2
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (&occ_q && legal) |-> !launch_ready); // R1
  AST_REJECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid && launch_ready && !legal) |=> (reject_valid && !grant_valid)); // R3
  AST_GRANT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid && launch_ready && legal) |=> (grant_valid && !reject_valid)); // R4
  AST_GRANT_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> occ_q[grant_slot]); // R5
  AST_WARP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (grant_warps != '0 && grant_warps <= WCNT_W'(WPS))); // R4
  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && occ_q[done_slot]) |=> !occ_q[$past(done_slot)]); // R7
endmodule

// File: tb/block_admit_ctrl_tb_top.sv
`timescale 1ns/1ps
module block_admit_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lv = 1'b0;
  logic [15:0] lid = '0;
  logic [15:0] lt = '0;
  logic dv = 1'b0;
  logic [2:0] ds = '0;
  logic launch_ready, grant_valid, reject_valid;
  logic [15:0] grant_block_id, reject_block_id;
  logic [2:0] grant_slot;
  logic [5:0] grant_warps;
  logic [7:0] grant_base_warp;
  logic [31:0] grant_tail_mask;

  always #2.5 clk = ~clk;

  block_admit_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(lv), .launch_ready(launch_ready),
    .launch_block_id(lid), .launch_threads(lt),
    .done_valid(dv), .done_slot(ds),
    .grant_valid(grant_valid), .grant_block_id(grant_block_id),
    .grant_slot(grant_slot), .grant_warps(grant_warps),
    .grant_base_warp(grant_base_warp), .grant_tail_mask(grant_tail_mask),
    .reject_valid(reject_valid), .reject_block_id(reject_block_id)
  );

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  int mocc[8];
  int mheld[8];
  int mtotal;
  bit eg, erj;
  int eid, eslot, ewarps, ebase, erid;
  longint emask;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 8; s++) begin mocc[s] = 0; mheld[s] = 0; end
      mtotal = 0; eg = 0; erj = 0;
    end else begin
      int t; bit lg; int fs; bit er; string tg;
      t = lt;
      lg = (t >= 1 && t <= 1024);
      fs = -1;
      for (int s = 7; s >= 0; s--) if (mocc[s] == 0) fs = s;
      er = !lg || (fs >= 0 && mtotal + t <= 1536);
      tg = !lg ? "R3" : (fs < 0 ? "R1" : "R2");
      chk(launch_ready == er, tg, "launch_ready", launch_ready, er);
      eg = 0; erj = 0;
      if (lv && er) begin
        if (lg) begin
          eg = 1; eid = lid; eslot = fs; ewarps = (t + 31) / 32; ebase = fs * 32;
          emask = 0;
          if (t % 32 == 0) emask = 64'hFFFF_FFFF;
          else for (int i = 0; i < t % 32; i++) emask[i] = 1'b1;
        end else begin
          erj = 1; erid = lid;
        end
      end
      if (dv && mocc[ds] != 0) begin
        mtotal -= mheld[ds]; mocc[ds] = 0; mheld[ds] = 0;
      end
      if (eg) begin mocc[fs] = 1; mheld[fs] = t; mtotal += t; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(grant_valid == eg, "R4", "grant_valid", grant_valid, eg);
      chk(reject_valid == erj, "R3", "reject_valid", reject_valid, erj);
      if (eg && grant_valid) begin
        chk(grant_block_id == eid, "R4", "grant_block_id", grant_block_id, eid);
        chk(grant_warps == ewarps, "R4", "grant_warps", grant_warps, ewarps);
        chk(grant_slot == eslot, "R5", "grant_slot", grant_slot, eslot);
        chk(grant_base_warp == ebase, "R5", "grant_base_warp", grant_base_warp, ebase);
        chk(grant_tail_mask == emask[31:0], "R6", "grant_tail_mask", grant_tail_mask, emask);
      end
      if (erj && reject_valid)
        chk(reject_block_id == erid, "R3", "reject_block_id", reject_block_id, erid);
    end
  end

  task automatic launch(input int id, input int t);
    @(negedge clk); lv = 1'b1; lid = 16'(id); lt = 16'(t);
    do @(posedge clk); while (!launch_ready);
    @(negedge clk); lv = 1'b0;
  endtask

  task automatic pulse_done(input int s);
    @(negedge clk); dv = 1'b1; ds = 3'(s);
    @(negedge clk); dv = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R9 watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lt = 16'd1024;
    @(negedge clk); #1;
    chk(grant_valid == 0, "R9", "grant_valid after reset", grant_valid, 0);
    chk(reject_valid == 0, "R9", "reject_valid after reset", reject_valid, 0);
    chk(launch_ready == 1, "R9", "ready after reset", launch_ready, 1);

    // R1: fill every slot, ninth block waits until slot 3 completes
    for (int b = 0; b < 8; b++) launch(b, 64);
    @(negedge clk); lv = 1'b1; lid = 16'd100; lt = 16'd64;
    repeat (3) begin
      @(negedge clk); #1;
      chk(launch_ready == 0, "R1", "ready with all slots full", launch_ready, 0);
    end
    dv = 1'b1; ds = 3'd3;
    @(negedge clk); dv = 1'b0; #1;
    chk(launch_ready == 1, "R7", "ready after completion", launch_ready, 1);
    @(posedge clk);
    @(negedge clk); lv = 1'b0;

    // R7: out-of-order completion, then a completion on a free slot
    for (int s = 7; s >= 0; s--) pulse_done(s);
    pulse_done(5);

    // R2: three 512-thread blocks reach the thread limit exactly
    launch(200, 512); launch(201, 512); launch(202, 512);
    @(negedge clk); lv = 1'b1; lid = 16'd203; lt = 16'd1;
    repeat (2) begin
      @(negedge clk); #1;
      chk(launch_ready == 0, "R2", "ready at thread limit", launch_ready, 0);
    end
    dv = 1'b1; ds = 3'd1;
    @(negedge clk); dv = 1'b0;
    @(posedge clk);
    @(negedge clk); lv = 1'b0;

    // R3: illegal counts are rejected
    launch(300, 0); launch(301, 1025); launch(302, 65535);

    // R8: completion and launch in the same cycle
    fork
      launch(400, 511);
      pulse_done(0);
    join
    for (int s = 0; s < 8; s++) pulse_done(s);

    // R6: tail masks for edge sizes
    launch(500, 1); launch(501, 31); launch(502, 32); launch(503, 33);
    for (int s = 0; s < 4; s++) pulse_done(s);
    launch(504, 1024); launch(505, 1023 - 511);
    for (int s = 0; s < 2; s++) pulse_done(s);

    // mixed traffic
    for (int c = 0; c < 3000; c++) begin
      int sel;
      @(negedge clk);
      lv = 1'($urandom % 2);
      lid = 16'($urandom);
      sel = $urandom % 10;
      if (sel == 0) lt = 16'd0;
      else if (sel == 1) lt = 16'(1025 + $urandom % 5000);
      else lt = 16'(1 + $urandom % 1024);
      dv = ($urandom % 3 == 0);
      ds = 3'($urandom);
    end
    @(negedge clk); lv = 1'b0; dv = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule